// File: doc/BRIEF.md
# Serial Audio Link Frame Timer

This block runs the bit-level timing of an AC'97-style serial link from the link's own bit clock. It counts a frame of `FRAME_BITS` bit periods (256 by default), drives a frame sync that is high for the opening `SYNC_BITS` periods, and shifts out a parallel outgoing frame one bit per period. Outgoing bits change on rising edges of the bit clock. Incoming bits are captured on the falling edge that follows, so the far end has half a period to settle.

Two kinds of event cross into a system clock that runs at least four times faster than the bit clock. The first is the start of each frame. The second is the completion of each received frame word. Each event is carried as a toggle through a synchronizer chain, and the receiving side turns it into a single-cycle pulse. The received word is copied into the system domain only when its pulse fires. The source register holds that word for a whole frame, so the copy is safe.

Top module: `acl_frame_gen`

## Requirements
- R1: While `rst` is high, `sync_o` and `sdata_o` are 0, `frame_stb_o` and `rx_valid_o` are 0, and `rx_data_o` is all zeros.
- R2: Once reset is released, `sync_o` is high for exactly the first `SYNC_BITS` (16) bit periods of every `FRAME_BITS` (256) period frame and low for the rest. The frame repeats with no gap.
- R3: `sync_o` and `sdata_o` change only on rising edges of `bclk`. They hold their values across the falling edge.
- R4: `tx_frame` is sampled at the rising edge that starts slot 0. Bit `FRAME_BITS-1` goes out in slot 0 and bit 0 goes out in the last slot, most significant bit first. Changing `tx_frame` during a frame has no effect on that frame.
- R5: `sdata_in` is sampled on the falling edge after each rising edge. The bit of slot 0 lands in `rx_data_o[FRAME_BITS-1]` and the bit of the last slot lands in `rx_data_o[0]`.
- R6: `frame_stb_o` is a one-cycle pulse in the `sys_clk` domain, given exactly once per frame within a few system cycles after the frame starts.
- R7: `rx_valid_o` is a one-cycle pulse, given once per completed received frame. `rx_data_o` changes only in a cycle where `rx_valid_o` is high.
- R8: No `rx_valid_o` pulse occurs before all `FRAME_BITS` slots of the first frame after reset have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock of the link |
| rst | input | 1 | Asynchronous active-high reset for both clock domains |
| sdata_in | input | 1 | Serial data from the far end |
| tx_frame | input | FRAME_BITS | Parallel outgoing frame, sampled at frame start |
| sync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data to the far end |
| sys_clk | input | 1 | System clock, at least four times the bit clock |
| frame_stb_o | output | 1 | One-cycle frame-start pulse in the system domain |
| rx_valid_o | output | 1 | One-cycle pulse marking a new received word |
| rx_data_o | output | FRAME_BITS | Last complete received frame word |

## Verification
A received word completes on the falling edge of the last slot, and the next frame starts on the rising edge half a bit period later. The two system-domain pulses therefore arrive in the same system cycle or in adjacent ones. The bench makes this happen in every frame by running back-to-back frames with the system clock only five times faster than the bit clock. A monitor samples both pulses on every system cycle and counts each one separately. It checks that neither pulse lasts two cycles and that the data word moves only together with its own pulse.

// File: rtl/acl_pkg.sv
package acl_pkg;
   localparam int unsigned ACL_FRAME_BITS_DEF  = 256;
   localparam int unsigned ACL_SYNC_BITS_DEF   = 16;
   localparam int unsigned ACL_SYNC_STAGES_DEF = 2;

   function automatic int unsigned acl_cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/acl_slot_timer.sv
module acl_slot_timer
   import acl_pkg::*;
#(
   parameter int unsigned FRAME_BITS = ACL_FRAME_BITS_DEF,
   parameter int unsigned SYNC_BITS  = ACL_SYNC_BITS_DEF,
   localparam int unsigned CW        = acl_cnt_width(FRAME_BITS)
)(
   input  logic          bclk,
   input  logic          rst,
   output logic [CW-1:0] slot_o,
   output logic          active_o,
   output logic          lead_o,
   output logic          sof_tog_o,
   output logic          sync_o
);
   logic [CW-1:0] slot_q;
   logic          active_q;
   logic          tog_q;
   logic          sync_q;
   logic          at_last;

   assign at_last = (slot_q == CW'(FRAME_BITS - 1));

   always_ff @(posedge bclk or posedge rst) begin
      if (rst) begin
         slot_q   <= '0;
         active_q <= 1'b0;
         tog_q    <= 1'b0;
         sync_q   <= 1'b0;
      end else begin
         active_q <= 1'b1;
         slot_q   <= at_last ? '0 : slot_q + 1'b1;
         sync_q   <= (slot_q < CW'(SYNC_BITS));
         if (slot_q == '0) tog_q <= ~tog_q;
      end
   end

   assign slot_o    = slot_q;
   assign active_o  = active_q;
   assign lead_o    = (slot_q == '0);
   assign sof_tog_o = tog_q;
   assign sync_o    = sync_q;

   AST_SYNC_RISE: assert property (@(posedge bclk) disable iff (rst)
      $rose(sync_q) |-> (slot_q == CW'(1)));                     // R2
   AST_SYNC_FALL: assert property (@(posedge bclk) disable iff (rst)
      $fell(sync_q) |-> (slot_q == CW'(SYNC_BITS + 1)));         // R2

   always @(posedge bclk) begin
      if (rst) AST_RST_QUIET: assert (!sync_q);                  // R1
   end
endmodule

// File: rtl/acl_tx_serializer.sv
module acl_tx_serializer
   import acl_pkg::*;
#(
   parameter int unsigned FRAME_BITS = ACL_FRAME_BITS_DEF,
   parameter bit          MSB_FIRST  = 1'b1
)(
   input  logic                  bclk,
   input  logic                  rst,
   input  logic                  load_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic                  sdo_o
);
   logic [FRAME_BITS-1:0] sh_q;
   logic [FRAME_BITS-1:0] src;
   logic [FRAME_BITS-1:0] sh_next;
   logic                  bit_next;
   logic                  sdo_q;

   assign src = load_i ? frame_i : sh_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_next = src[FRAME_BITS-1];
         assign sh_next  = {src[FRAME_BITS-2:0], 1'b0};
         AST_TX_FIRST_BIT: assert property (@(posedge bclk) disable iff (rst)
            load_i |=> (sdo_q == $past(frame_i[FRAME_BITS-1])));  // R4
      end else begin : g_lsb
         assign bit_next = src[0];
         assign sh_next  = {1'b0, src[FRAME_BITS-1:1]};
         AST_TX_FIRST_BIT: assert property (@(posedge bclk) disable iff (rst)
            load_i |=> (sdo_q == $past(frame_i[0])));             // R4
      end
   endgenerate

   always_ff @(posedge bclk or posedge rst) begin
      if (rst) begin
         sh_q  <= '0;
         sdo_q <= 1'b0;
      end else begin
         sh_q  <= sh_next;
         sdo_q <= bit_next;
      end
   end

   assign sdo_o = sdo_q;

   always @(posedge bclk) begin
      if (rst) AST_RST_SDO_LOW: assert (!sdo_q);                 // R1
   end
endmodule

// File: rtl/acl_rx_deserializer.sv
module acl_rx_deserializer
   import acl_pkg::*;
#(
   parameter int unsigned FRAME_BITS = ACL_FRAME_BITS_DEF,
   parameter bit          MSB_FIRST  = 1'b1
)(
   input  logic                  bclk,
   input  logic                  rst,
   input  logic                  active_i,
   input  logic                  wrap_i,
   input  logic                  sdi_i,
   output logic [FRAME_BITS-1:0] word_o,
   output logic                  done_tog_o
);
   logic [FRAME_BITS-1:0] sh_q;
   logic [FRAME_BITS-1:0] sh_next;
   logic [FRAME_BITS-1:0] word_q;
   logic                  tog_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh_q[FRAME_BITS-2:0], sdi_i};
      end else begin : g_lsb
         assign sh_next = {sdi_i, sh_q[FRAME_BITS-1:1]};
      end
   endgenerate

   always_ff @(negedge bclk or posedge rst) begin
      if (rst) begin
         sh_q   <= '0;
         word_q <= '0;
         tog_q  <= 1'b0;
      end else if (active_i) begin
         sh_q <= sh_next;
         if (wrap_i) begin
            word_q <= sh_next;
            tog_q  <= ~tog_q;
         end
      end
   end

   assign word_o     = word_q;
   assign done_tog_o = tog_q;

   AST_RX_IDLE_HOLD: assert property (@(negedge bclk) disable iff (rst)
      !active_i |=> $stable(tog_q));                             // R8
endmodule

// File: rtl/acl_tog_sync.sv
module acl_tog_sync
   import acl_pkg::*;
#(
   parameter int unsigned STAGES = ACL_SYNC_STAGES_DEF
)(
   input  logic clk,
   input  logic rst,
   input  logic tog_i,
   output logic pulse_o
);
   logic [STAGES-1:0] chain_q;
   logic              seen_q;
   logic              pulse_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or posedge rst) begin
               if (rst) chain_q[i] <= 1'b0;
               else     chain_q[i] <= tog_i;
            end
         end else begin : g_link
            always_ff @(posedge clk or posedge rst) begin
               if (rst) chain_q[i] <= 1'b0;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         seen_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         seen_q  <= chain_q[STAGES-1];
         pulse_q <= chain_q[STAGES-1] ^ seen_q;
      end
   end

   assign pulse_o = pulse_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      pulse_q |=> !pulse_q);                                     // R6
endmodule

// File: rtl/acl_frame_gen.sv
module acl_frame_gen
   import acl_pkg::*;
#(
   parameter int unsigned FRAME_BITS  = ACL_FRAME_BITS_DEF,
   parameter int unsigned SYNC_BITS   = ACL_SYNC_BITS_DEF,
   parameter int unsigned SYNC_STAGES = ACL_SYNC_STAGES_DEF,
   parameter bit          MSB_FIRST   = 1'b1
)(
   input  logic                  bclk,
   input  logic                  rst,
   input  logic                  sdata_in,
   input  logic [FRAME_BITS-1:0] tx_frame,
   output logic                  sync_o,
   output logic                  sdata_o,
   input  logic                  sys_clk,
   output logic                  frame_stb_o,
   output logic                  rx_valid_o,
   output logic [FRAME_BITS-1:0] rx_data_o
);
   localparam int unsigned CW = acl_cnt_width(FRAME_BITS);

   if (SYNC_BITS == 0 || SYNC_BITS >= FRAME_BITS) begin : g_bad_sync
      $error("acl_frame_gen: SYNC_BITS must lie in 1..FRAME_BITS-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("acl_frame_gen: SYNC_STAGES must be at least 2");
   end
   if (FRAME_BITS < 4) begin : g_bad_frame
      $error("acl_frame_gen: FRAME_BITS must be at least 4");
   end

   logic [CW-1:0]         slot;
   logic                  active;
   logic                  lead;
   logic                  sof_tog;
   logic [FRAME_BITS-1:0] rx_word;
   logic                  rx_tog;
   logic                  rx_pulse;
   logic                  rx_valid_q;
   logic [FRAME_BITS-1:0] rx_data_q;

   acl_slot_timer #(.FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS)) u_timer (
      .bclk(bclk), .rst(rst), .slot_o(slot), .active_o(active),
      .lead_o(lead), .sof_tog_o(sof_tog), .sync_o(sync_o)
   );

   acl_tx_serializer #(.FRAME_BITS(FRAME_BITS), .MSB_FIRST(MSB_FIRST)) u_tx (
      .bclk(bclk), .rst(rst), .load_i(lead), .frame_i(tx_frame), .sdo_o(sdata_o)
   );

   acl_rx_deserializer #(.FRAME_BITS(FRAME_BITS), .MSB_FIRST(MSB_FIRST)) u_rx (
      .bclk(bclk), .rst(rst), .active_i(active), .wrap_i(slot == '0),
      .sdi_i(sdata_in), .word_o(rx_word), .done_tog_o(rx_tog)
   );

   acl_tog_sync #(.STAGES(SYNC_STAGES)) u_sof_sync (
      .clk(sys_clk), .rst(rst), .tog_i(sof_tog), .pulse_o(frame_stb_o)
   );

   acl_tog_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
      .clk(sys_clk), .rst(rst), .tog_i(rx_tog), .pulse_o(rx_pulse)
   );

   always_ff @(posedge sys_clk or posedge rst) begin
      if (rst) begin
         rx_valid_q <= 1'b0;
         rx_data_q  <= '0;
      end else begin
         rx_valid_q <= rx_pulse;
         if (rx_pulse) rx_data_q <= rx_word;
      end
   end

   assign rx_valid_o = rx_valid_q;
   assign rx_data_o  = rx_data_q;

   AST_RX_DATA_HOLD: assert property (@(posedge sys_clk) disable iff (rst)
      !rx_valid_q |-> $stable(rx_data_q));                       // R7
   AST_RX_VALID_SINGLE: assert property (@(posedge sys_clk) disable iff (rst)
      rx_valid_q |=> !rx_valid_q);                               // R7
endmodule

// File: tb/sim_acl_frame_gen.sv
module sim_acl_frame_gen;
   localparam int FB          = 256;
   localparam int SB          = 16;
   localparam int CLK_PERIOD  = 8;
   localparam int BCLK_PERIOD = 40;
   localparam int NV          = 4;
   localparam logic [63:0] VEC [NV] = '{
      {32'hA5C3_0F81, 32'h1234_5678},
      {32'hFFFF_0000, 32'h0000_FFFF},
      {32'h8000_0001, 32'hDEAD_BEEF},
      {32'h0000_0000, 32'hFFFF_FFFF}
   };

   logic          bclk = 1'b0;
   logic          sys_clk = 1'b0;
   logic          rst = 1'b1;
   logic          sdata_in = 1'b0;
   logic [FB-1:0] tx_frame = '0;
   logic          sync_o, sdata_o, frame_stb_o, rx_valid_o;
   logic [FB-1:0] rx_data_o;

   int checks = 0;
   int fails  = 0;
   int fstb_n = 0;
   int rxv_n  = 0;
   logic [FB-1:0] last_rx = '0;
   logic [FB-1:0] prev_data = '0;
   logic stb_prev = 1'b0;
   logic rxv_prev = 1'b0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2)  sys_clk = ~sys_clk;
   always #(BCLK_PERIOD/2) bclk = ~bclk;

   acl_frame_gen u0 (
      .bclk(bclk), .rst(rst), .sdata_in(sdata_in), .tx_frame(tx_frame),
      .sync_o(sync_o), .sdata_o(sdata_o), .sys_clk(sys_clk),
      .frame_stb_o(frame_stb_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
   );

   function automatic logic [FB-1:0] rep(logic [31:0] w);
      return {8{w}};
   endfunction

   task automatic chk(bit ok, string req, logic [FB-1:0] act, logic [FB-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // system-domain monitor, sampled on the falling system edge
   always @(negedge sys_clk) begin
      if (!rst) begin
         if (frame_stb_o) begin
            fstb_n++;
            chk(!stb_prev, "R6 strobe width", FB'(stb_prev), '0);
         end
         if (rx_valid_o) begin
            rxv_n++;
            last_rx = rx_data_o;
            chk(!rxv_prev, "R7 valid width", FB'(rxv_prev), '0);
         end else if (rx_data_o != prev_data) begin
            chk(1'b0, "R7 data moved without valid", rx_data_o, prev_data);
         end
      end
      stb_prev  = frame_stb_o;
      rxv_prev  = rx_valid_o;
      prev_data = rx_data_o;
   end

   initial begin
      #(BCLK_PERIOD * FB * 12);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [FB-1:0] txp, rxp, prev_rxp;
      int fbase, rbase;
      tx_frame = rep(VEC[0][63:32]);
      prev_rxp = '0;
      #(BCLK_PERIOD * 5 + 3);
      // R1 reset state
      chk(sync_o == 1'b0, "R1 sync in reset", FB'(sync_o), '0);
      chk(sdata_o == 1'b0, "R1 sdata in reset", FB'(sdata_o), '0);
      chk(frame_stb_o == 1'b0, "R1 strobe in reset", FB'(frame_stb_o), '0);
      chk(rx_valid_o == 1'b0, "R1 valid in reset", FB'(rx_valid_o), '0);
      chk(rx_data_o == '0, "R1 data in reset", rx_data_o, '0);
      @(negedge bclk);
      rst = 1'b0;

      // vector table walk: NV frames plus one trailing frame
      for (int v = 0; v <= NV; v++) begin
         txp = rep(VEC[v % NV][63:32]);
         rxp = rep(VEC[v % NV][31:0]);
         for (int s = 0; s < FB; s++) begin
            @(posedge bclk);
            #10;
            chk(sync_o == (s < SB), "R2 sync shape", FB'(sync_o), FB'(s < SB));
            chk(sdata_o == txp[FB-1-s], "R4 serial out bit", FB'(sdata_o), FB'(txp[FB-1-s]));
            sdata_in = rxp[FB-1-s];
            if (s == 10) begin
               chk(fstb_n == v + 1, "R6 one strobe per frame", FB'(fstb_n), FB'(v + 1));
               if (v > 0) begin
                  chk(rxv_n == v, "R7 one valid per frame", FB'(rxv_n), FB'(v));
                  chk(last_rx == prev_rxp, "R5 received word", last_rx, prev_rxp);
               end
            end
            if (v == 0 && s == 200)
               chk(rxv_n == 0, "R8 no word before full frame", FB'(rxv_n), '0);
            if (s == 100) tx_frame = ~txp;   // R4 mid-frame change ignored
            if (s == FB - 1) tx_frame = rep(VEC[(v + 1) % NV][63:32]);
            #20;
            chk(sdata_o == txp[FB-1-s], "R3 out held over falling edge", FB'(sdata_o), FB'(txp[FB-1-s]));
            chk(sync_o == (s < SB), "R3 sync held over falling edge", FB'(sync_o), FB'(s < SB));
         end
         prev_rxp = rxp;
      end

      // directed: reset in the middle of a frame
      for (int s = 0; s < 50; s++) @(posedge bclk);
      #10;
      rst = 1'b1;
      #1;
      chk(sync_o == 1'b0, "R1 sync on mid-frame reset", FB'(sync_o), '0);
      chk(sdata_o == 1'b0, "R1 sdata on mid-frame reset", FB'(sdata_o), '0);
      #(BCLK_PERIOD * 3);
      chk(rx_data_o == '0, "R1 data cleared", rx_data_o, '0);
      chk(rx_valid_o == 1'b0 && frame_stb_o == 1'b0, "R1 pulses low", FB'({rx_valid_o, frame_stb_o}), '0);
      fbase = fstb_n;
      rbase = rxv_n;
      txp = tx_frame;
      @(negedge bclk);
      rst = 1'b0;
      for (int s = 0; s < 40; s++) begin
         @(posedge bclk);
         #10;
         chk(sync_o == (s < SB), "R2 sync restarts at slot 0", FB'(sync_o), FB'(s < SB));
         chk(sdata_o == txp[FB-1-s], "R4 restart bit order", FB'(sdata_o), FB'(txp[FB-1-s]));
         if (s == 10)
            chk(fstb_n == fbase + 1, "R6 strobe after restart", FB'(fstb_n), FB'(fbase + 1));
         if (s == 39)
            chk(rxv_n == rbase, "R8 no word in partial frame", FB'(rxv_n), FB'(rbase));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule